// File: doc/BRIEF.md
# Unaligned Load Sequencer for a Word-Only Memory Bus

This block sits between a load pipeline and a 32-bit memory bus that can only address whole, aligned words. It takes byte, halfword and word loads at any byte address. It turns each load into one or two aligned word reads. It then shifts the returned data and combines it, so the requested bytes come out right-justified in a 32-bit result. Byte and halfword results can be sign-extended or zero-extended.

Only one load is in flight at a time. A request is accepted by a valid/ready handshake, and the result comes back as a single-cycle response pulse.

A strict-alignment input changes how misaligned loads are handled. With it set, any load that is not naturally aligned completes at once with a fault flag and touches no bus. With it clear, a load whose bytes cross a word boundary is served with two bus reads. Loads that are misaligned but stay inside one word always need just one read.

Top module: `uld_top`

## Requirements
- R1: The word address on the bus is the request byte address with its two low bits removed. The first read of every access goes to the word that holds the lowest requested byte.
- R2: An access whose bytes all lie inside one aligned word uses exactly one bus read, even when it is not naturally aligned. For example, a halfword at byte address 5 reads word 1 and returns bytes 5 and 6.
- R3: An access that crosses a word boundary uses exactly two bus reads. The second read goes to the next higher word address, wrapping modulo the word address space.
- R4: Byte order is little-endian: the lowest byte address lands in result bits 7:0. For a two-read access the result is the first word shifted right by 8×offset, ORed with the second word shifted left by 8×(4−offset).
- R5: The size field encodes the access width: 0 is a byte, 1 is a halfword, 2 is a word, and 3 is treated as a word. A halfword crosses a word boundary only at offset 3. A word crosses one at any non-zero offset.
- R6: When strict mode is high at acceptance, a load that is not naturally aligned is answered with rsp_fault high and issues no bus read. A halfword with address bit 0 set is such a load, and so is a word with address bits 1:0 non-zero. Naturally aligned loads are served normally in strict mode.
- R7: When req_signed is high, byte and halfword results are sign-extended to 32 bits. Otherwise they are zero-extended.
- R8: req_ready is low from the cycle after acceptance until the response has been given. rsp_valid lasts exactly one cycle per accepted request, and never occurs without one.
- R9: bus_rd and bus_addr stay steady until bus_rvalid arrives, for any number of memory wait cycles.
- R10: After reset, req_ready is high and both bus_rd and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strict_mode | input | 1 | Fault on loads that are not naturally aligned |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | Access width: 0 byte, 1 half, 2 or 3 word |
| req_signed | input | 1 | Sign-extend byte or halfword result |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 32 | Right-justified load result |
| rsp_fault | output | 1 | Misalignment fault for this response |
| bus_rd | output | 1 | Read strobe to memory |
| bus_addr | output | AW-2 | Word address to memory |
| bus_rdata | input | 32 | Read data from memory |
| bus_rvalid | input | 1 | Read data valid, one cycle per read |

## Verification
The assertions assume the memory raises bus_rvalid for exactly one cycle per read, and only while bus_rd is high. They also assume it never answers a read that has not been asked for.

The bench memory model holds the valid for a single cycle, after a wait count that the stimulus changes between passes (0, 2 and 5). Requests are presented only while req_ready is high, and only after the previous response has arrived.

The reference computes each expected result byte by byte from the memory contents. It covers every offset and size, and also the wrap from the last word back to word zero.

// File: rtl/uld_pkg.sv
package uld_pkg;

    localparam int DATA_W = 32;
    localparam int BYTES  = DATA_W / 8;
    localparam int OFS_W  = $clog2(BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD2 = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD1,
        S_RD2,
        S_RESP,
        S_FLT
    } state_e;

    function automatic logic [OFS_W+1:0] size_bytes(input size_e sz);
        case (sz)
            SZ_BYTE: size_bytes = (OFS_W+2)'(1);
            SZ_HALF: size_bytes = (OFS_W+2)'(2);
            default: size_bytes = (OFS_W+2)'(BYTES);
        endcase
    endfunction

endpackage

// File: rtl/uld_plan.sv
module uld_plan
    import uld_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  size_e            size,
    input  logic             strict,
    output logic             span,
    output logic             misal,
    output logic             fault
);
    logic [OFS_W+1:0] nbytes;
    logic [OFS_W+1:0] last;

    always_comb begin
        nbytes = size_bytes(size);
        last   = {2'b00, ofs} + nbytes;
        span   = last > (OFS_W+2)'(BYTES);
        misal  = ({2'b00, ofs} & (nbytes - 1'b1)) != '0;
        fault  = strict & misal;
    end
endmodule

// File: rtl/uld_merge.sv
module uld_merge
    import uld_pkg::*;
(
    input  logic [DATA_W-1:0] w_lo,
    input  logic [DATA_W-1:0] w_hi,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              span,
    input  size_e             size,
    input  logic              sgn,
    output logic [DATA_W-1:0] data
);
    logic [OFS_W:0]    rem;
    logic [OFS_W+3:0]  sh_lo;
    logic [OFS_W+3:0]  sh_hi;
    logic [DATA_W-1:0] part_lo;
    logic [DATA_W-1:0] part_hi;
    logic [DATA_W-1:0] raw;

    always_comb begin
        rem     = (OFS_W+1)'(BYTES) - {1'b0, ofs};
        sh_lo   = {2'b00, ofs, 3'b000};
        sh_hi   = {1'b0, rem, 3'b000};
        part_lo = w_lo >> sh_lo;
        part_hi = span ? (w_hi << sh_hi) : '0;
        raw     = part_lo | part_hi;
        case (size)
            SZ_BYTE: data = {{(DATA_W-8){sgn & raw[7]}}, raw[7:0]};
            SZ_HALF: data = {{(DATA_W-16){sgn & raw[15]}}, raw[15:0]};
            default: data = raw;
        endcase
    end
endmodule

// File: rtl/uld_fsm.sv
module uld_fsm
    import uld_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fire,
    input  logic   fault,
    input  logic   span_q,
    input  logic   rvalid,
    output state_e state
);
    state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE: if (fire) nxt = fault ? S_FLT : S_RD1;
            S_RD1:  if (rvalid) nxt = span_q ? S_RD2 : S_RESP;
            S_RD2:  if (rvalid) nxt = S_RESP;
            S_RESP: nxt = S_IDLE;
            S_FLT:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    assert_resp_returns_R8: assert property (@(posedge clk) disable iff (rst)
        (state == S_RESP || state == S_FLT) |=> state == S_IDLE);
endmodule

// File: rtl/uld_top.sv
module uld_top
    import uld_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strict_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_fault,
    output logic              bus_rd,
    output logic [AW-3:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rvalid
);
    localparam int WAW = AW - OFS_W;

    state_e            state;
    logic              fire;
    logic              span_in, misal_in, fault_in;
    logic [AW-1:0]     addr_q;
    size_e             size_q;
    logic              sgn_q;
    logic              span_q;
    logic [DATA_W-1:0] w0_q, w1_q;
    logic [DATA_W-1:0] merged;
    logic [WAW-1:0]    base_w;

    assign req_ready = (state == S_IDLE);
    assign fire      = req_valid & req_ready;

    uld_plan u_plan (
        .ofs    (req_addr[OFS_W-1:0]),
        .size   (size_e'(req_size)),
        .strict (strict_mode),
        .span   (span_in),
        .misal  (misal_in),
        .fault  (fault_in)
    );

    uld_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .fault  (fault_in),
        .span_q (span_q),
        .rvalid (bus_rvalid),
        .state  (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            size_q <= SZ_BYTE;
            sgn_q  <= 1'b0;
            span_q <= 1'b0;
            w0_q   <= '0;
            w1_q   <= '0;
        end else begin
            if (fire) begin
                addr_q <= req_addr;
                size_q <= size_e'(req_size);
                sgn_q  <= req_signed;
                span_q <= span_in;
            end
            if (state == S_RD1 && bus_rvalid) w0_q <= bus_rdata;
            if (state == S_RD2 && bus_rvalid) w1_q <= bus_rdata;
        end
    end

    assign base_w   = addr_q[AW-1:OFS_W];
    assign bus_rd   = (state == S_RD1) || (state == S_RD2);
    assign bus_addr = (state == S_RD2) ? base_w + 1'b1 : base_w;

    uld_merge u_merge (
        .w_lo (w0_q),
        .w_hi (w1_q),
        .ofs  (addr_q[OFS_W-1:0]),
        .span (span_q),
        .size (size_q),
        .sgn  (sgn_q),
        .data (merged)
    );

    assign rsp_valid = (state == S_RESP) || (state == S_FLT);
    assign rsp_fault = (state == S_FLT);
    assign rsp_data  = (state == S_RESP) ? merged : '0;

    assert_hold_bus_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_rvalid) |=> (bus_rd && $stable(bus_addr)));

    assert_next_word_R3: assert property (@(posedge clk) disable iff (rst)
        (state == S_RD1 && bus_rvalid && span_q) |=>
        (bus_rd && bus_addr == $past(bus_addr) + 1'b1));

    assert_single_read_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_RD1 && bus_rvalid && !span_q) |=> (!bus_rd && rsp_valid));

    assert_fault_no_bus_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && strict_mode && misal_in) |=> (!bus_rd && rsp_valid && rsp_fault));

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
        fire |=> !req_ready);

    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_first_word_R1: assert property (@(posedge clk) disable iff (rst)
        fire |=> (rsp_fault || bus_addr == $past(req_addr[AW-1:OFS_W])));
endmodule

// File: tb/uld_top_bench.sv
module uld_top_bench;
    localparam int AW = 8;
    localparam int NB = 1 << AW;

    logic        clk = 1'b0;
    logic        rst;
    logic        strict_mode;
    logic        req_valid;
    logic        req_ready;
    logic [AW-1:0] req_addr;
    logic [1:0]  req_size;
    logic        req_signed;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_fault;
    logic        bus_rd;
    logic [AW-3:0] bus_addr;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int checks = 0;
    int errors = 0;
    int wait_n = 0;
    int wcnt   = 0;
    int nreads = 0;
    int rd_addr [0:3];
    bit pending = 0;

    always #2ns clk = ~clk;

    uld_top #(.AW(AW)) u_uld_top (
        .clk, .rst, .strict_mode, .req_valid, .req_ready, .req_addr,
        .req_size, .req_signed, .rsp_valid, .rsp_data, .rsp_fault,
        .bus_rd, .bus_addr, .bus_rdata, .bus_rvalid
    );

    function automatic logic [7:0] mbyte(input int a);
        int b = a % NB;
        return 8'((b * 29 + 7) ^ (b >> 1) ^ ((b & 3) << 6));
    endfunction

    function automatic logic [31:0] mword(input int w);
        return {mbyte(4*w+3), mbyte(4*w+2), mbyte(4*w+1), mbyte(4*w)};
    endfunction

    // memory model with a variable wait count
    always @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
            wcnt       <= 0;
        end else if (bus_rd && !bus_rvalid) begin
            if (wcnt >= wait_n) begin
                bus_rvalid <= 1'b1;
                bus_rdata  <= mword(int'(bus_addr));
                wcnt       <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            bus_rvalid <= 1'b0;
            if (!bus_rd) wcnt <= 0;
        end
    end

    always @(posedge clk) begin
        if (!rst && bus_rd && bus_rvalid) begin
            if (nreads < 4) rd_addr[nreads] = int'(bus_addr);
            nreads = nreads + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R8: a response may never appear without a request in flight
    always @(negedge clk) begin
        if (!rst && rsp_valid && !pending) chk("R8 stray response", 32'(rsp_valid), 32'd0);
    end

    task automatic do_req(input int a, input int sz, input bit sg, input bit st);
        int n;
        int ofs;
        bit span;
        bit misal;
        bit flt;
        logic [31:0] exp;
        int t;
        n     = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        ofs   = a & 3;
        span  = (ofs + n) > 4;
        misal = (ofs % n) != 0;
        flt   = st && misal;
        exp   = 0;
        for (int i = 0; i < n; i++) exp |= 32'(mbyte(a + i)) << (8*i);
        if (sg && n == 1) exp = {{24{exp[7]}}, exp[7:0]};
        if (sg && n == 2) exp = {{16{exp[15]}}, exp[15:0]};

        @(negedge clk);
        nreads      = 0;
        req_valid   = 1'b1;
        req_addr    = AW'(a);
        req_size    = 2'(sz);
        req_signed  = sg;
        strict_mode = st;
        pending     = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 busy after accept", 32'(req_ready), 32'd0);
        t = 0;
        while (!rsp_valid && t < 500) begin
            @(negedge clk);
            t++;
        end
        chk("R8 response arrives", 32'(rsp_valid), 32'd1);
        chk("R6 fault flag", 32'(rsp_fault), 32'(flt));
        if (flt) begin
            chk("R6 no bus read on fault", 32'(nreads), 32'd0);
        end else begin
            chk(span ? "R3 two reads" : "R2 one read", 32'(nreads), span ? 32'd2 : 32'd1);
            chk("R1 first word address", 32'(rd_addr[0]), 32'(a >> 2));
            if (span)
                chk("R3 second word address", 32'(rd_addr[1]), 32'(((a >> 2) + 1) % (NB/4)));
            chk(sz == 2 ? "R4 word result" : (sg ? "R7 signed result" : "R7 unsigned result"),
                rsp_data, exp);
        end
        @(negedge clk);
        pending = 1'b0;
        chk("R8 single-cycle response", 32'(rsp_valid), 32'd0);
        chk("R8 ready again", 32'(req_ready), 32'd1);
    endtask

    initial begin
        #600000ns;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0;
        req_signed = 1'b0; strict_mode = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 reset ready", 32'(req_ready), 32'd1);
        chk("R10 reset bus idle", 32'(bus_rd), 32'd0);
        chk("R10 reset no response", 32'(rsp_valid), 32'd0);

        // R2: halfword at address 5 stays within word 1
        do_req(5, 1, 0, 0);
        // R5: halfword at offset 3 crosses, offset 1 does not
        do_req(7, 1, 1, 0);
        do_req(9, 1, 1, 0);
        // R3: wrap from last word to word zero
        do_req(NB-1, 2, 0, 0);
        do_req(NB-3, 1, 0, 0);
        // R5: size code 3 behaves as a word
        do_req(22, 3, 0, 0);

        foreach (rd_addr[k]) rd_addr[k] = 0;
        for (int w = 0; w < 3; w++) begin
            wait_n = (w == 0) ? 0 : (w == 1) ? 2 : 5;
            for (int a = 16 + 8*w; a < 24 + 8*w; a++)
                for (int sz = 0; sz < 3; sz++)
                    for (int sg = 0; sg < 2; sg++)
                        do_req(a, sz, sg[0], 1'b0);
        end

        // R6: strict mode faults misaligned, serves aligned
        wait_n = 1;
        for (int a = 40; a < 48; a++)
            for (int sz = 0; sz < 3; sz++)
                do_req(a, sz, 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule